// File: doc/BRIEF.md
# Stereo Audio Transmit Queue and Status

This block sits in front of a stereo serial-audio transmitter. It keeps one small first-in first-out queue per channel. Software writes left and right samples into the queues, and each channel's shift register draws its next word from the head of its own queue. Alongside the queues, the block assembles a 9-bit live status word. That word reports, per channel, completion, free room and the half-empty level, plus a pause acknowledgement, a starvation flag for DMA operation and a sticky error flag. The error code that belongs to the error flag is held next to it.

Two feed modes are supported, chosen by `dma_mode`. In register mode (`dma_mode`=0) the queues carry the data, and a channel counts as done once its queue and shift register have both run dry after the transmitter has been switched off. In DMA mode (`dma_mode`=1) the queues are bypassed. Completion then follows each channel's end-of-transfer indication from the DMA socket.

The serializer, the bit clock and the DMA engine all live outside this block. Of those, only the shift-register-empty flags, the pop strobes and the frame-boundary strobe reach it.

Top module: `i2s_tx_status`

## Requirements
- R1: The status word carries left done at bit 0, left space at bit 1, left half at bit 2, right done at bit 3, right space at bit 4, right half at bit 5, paused at bit 6, no-data at bit 7 and error at bit 8.
- R2: After a synchronous active-low reset, the done, paused, no-data and error bits read 0, the space and half bits read 1, and the stored error code reads 0.
- R3: Each queue holds 16 words. Space is 1 while occupancy is below 16, and half is 1 while occupancy is 8 or fewer. Both flags follow a write or pop from the next cycle on. A write to a full queue is dropped, and a pop from an empty queue is ignored. A write and a pop in the same cycle leave occupancy unchanged.
- R4: Words leave each queue in write order, and the head word is presented on that channel's read-data output.
- R5: In register mode, a channel's done bit is 1 exactly when transmission has started, `enable` is 0, its queue is empty and its shift register is empty. This is evaluated combinationally in the current cycle.
- R6: In DMA mode, a channel's done bit is 1 exactly when transmission has started, that channel's end-of-transfer input is 1 and its shift register is empty.
- R7: Transmission counts as started from the cycle after `enable` is first seen high following reset. Before that, both done bits stay 0 whatever the other inputs are.
- R8: Paused becomes 1 in the cycle after a frame-boundary strobe at which the pause request is high and both shift registers are empty. It returns to 0 in the cycle after the pause request is seen low.
- R9: No-data is 1 exactly when `dma_mode` is 1, `sock_has_data` is 0 and neither end-of-transfer input is 1. It is always 0 in register mode.
- R10: An error pulse sets the error bit from the next cycle on. The bit holds until a clear strobe (`err_clr`, a status write with a one in bit 8). When a pulse and a clear fall in the same cycle, the error bit stays set.
- R11: The error code is captured from the first error pulse while the error bit is clear. Later pulses do not replace it until a clear. A pulse that coincides with a clear captures its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_left | input | 1 | Write strobe for the left queue |
| wr_data_left | input | 16 | Sample written to the left queue |
| wr_right | input | 1 | Write strobe for the right queue |
| wr_data_right | input | 16 | Sample written to the right queue |
| pop_left | input | 1 | Left shift register takes the head word |
| pop_right | input | 1 | Right shift register takes the head word |
| rd_data_left | output | 16 | Head word of the left queue |
| rd_data_right | output | 16 | Head word of the right queue |
| enable | input | 1 | Transmitter enable |
| pause_req | input | 1 | Pause request |
| frame_edge | input | 1 | Frame-boundary strobe |
| dma_mode | input | 1 | 1 selects DMA feed, 0 selects register feed |
| eot_left | input | 1 | Socket end-of-transfer, left channel |
| eot_right | input | 1 | Socket end-of-transfer, right channel |
| sock_has_data | input | 1 | Socket has data ready |
| sreg_empty_left | input | 1 | Left shift register is empty |
| sreg_empty_right | input | 1 | Right shift register is empty |
| err_pulse | input | 1 | Internal error event |
| err_code_in | input | 4 | Cause of the error event |
| err_clr | input | 1 | Write-one-to-clear of the error bit |
| status | output | 9 | Status word |
| err_code | output | 4 | Stored error cause |

## Verification
Two collisions matter here. An error event can coincide with the clear strobe, and a write can land on the same queue in the same cycle as a pop, including when the queue is full or empty. The random phase drives all of these strobes independently, so each collision turns up many times. Directed steps add a set-and-clear cycle and a write-into-full cycle. After every cycle, a reference model in the bench predicts the status word, the head words and the stored code, and the bench compares the design against those predictions. The error bit must survive the collision and take on the new code, and occupancy must come out unchanged whenever a write and a pop are both accepted.

// File: rtl/i2s_tx_status_pkg.sv
// Package: i2s_tx_status_pkg
// Shared status-word field positions and widths for the stereo transmit
// status block. Assumes a 9-bit status word with fixed field positions.
package i2s_tx_status_pkg;
    localparam int ST_W       = 9;
    localparam int BIT_L_DONE = 0;
    localparam int BIT_L_ROOM = 1;
    localparam int BIT_L_HALF = 2;
    localparam int BIT_R_DONE = 3;
    localparam int BIT_R_ROOM = 4;
    localparam int BIT_R_HALF = 5;
    localparam int BIT_PAUSED = 6;
    localparam int BIT_NODATA = 7;
    localparam int BIT_ERROR  = 8;
    localparam int NUM_CH     = 2;
endpackage

// File: rtl/i2s_txst_fifo.sv
// Module: i2s_txst_fifo
// One channel's sample queue. It reports empty, room-available and
// half-empty from a registered occupancy count. Assumes DEPTH >= 2. Writes
// to a full queue and pops from an empty one are dropped.
module i2s_txst_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              room,
    output logic              half
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  occ;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              wr_ok, rd_ok;

    assign wr_ok = wr_en && (occ < FULL_CNT);
    assign rd_ok = rd_en && (occ != '0);

    // Store accepted samples at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy on accepted writes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            if (rd_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            if (wr_ok && !rd_ok)      occ <= occ + CNT_W'(1);
            else if (rd_ok && !wr_ok) occ <= occ - CNT_W'(1);
        end
    end

    // Present the head word and the level flags.
    always_comb begin
        rd_data = mem[rd_ptr];
        empty   = (occ == '0);
        room    = (occ < FULL_CNT);
        half    = (occ <= HALF_CNT);
    end

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_CNT);
    assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !room) |=> !room);
    assert_empty_pop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && empty) |=> empty);
endmodule

// File: rtl/i2s_txst_err.sv
// Module: i2s_txst_err
// Sticky error flag with a captured cause code. A set wins over a
// coinciding clear. The code is taken only when the flag is clear or
// is being cleared in that same cycle.
module i2s_txst_err #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_pulse,
    input  logic [CODE_W-1:0] err_code_in,
    input  logic              err_clr,
    output logic              err_flag,
    output logic [CODE_W-1:0] err_code
);
    // Hold the flag and the first cause until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= '0;
        end else begin
            err_flag <= err_pulse || (err_flag && !err_clr);
            if (err_pulse && (!err_flag || err_clr)) err_code <= err_code_in;
        end
    end

    assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> err_flag);
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
    assert_code_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> $stable(err_code));
endmodule

// File: rtl/i2s_tx_status.sv
// Module: i2s_tx_status
// Stereo transmit queues with a live status word. Assumes the pop
// strobes come from the shift registers and frame_edge marks frame
// boundaries. Serialization and the DMA engine sit outside.
module i2s_tx_status
    import i2s_tx_status_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_left,
    input  logic [DATA_W-1:0] wr_data_left,
    input  logic              wr_right,
    input  logic [DATA_W-1:0] wr_data_right,
    input  logic              pop_left,
    input  logic              pop_right,
    output logic [DATA_W-1:0] rd_data_left,
    output logic [DATA_W-1:0] rd_data_right,
    input  logic              enable,
    input  logic              pause_req,
    input  logic              frame_edge,
    input  logic              dma_mode,
    input  logic              eot_left,
    input  logic              eot_right,
    input  logic              sock_has_data,
    input  logic              sreg_empty_left,
    input  logic              sreg_empty_right,
    input  logic              err_pulse,
    input  logic [CODE_W-1:0] err_code_in,
    input  logic              err_clr,
    output logic [ST_W-1:0]   status,
    output logic [CODE_W-1:0] err_code
);
    logic [NUM_CH-1:0]     ch_wr, ch_rd, ch_empty, ch_room, ch_half, ch_eot, ch_sreg, ch_done;
    logic [DATA_W-1:0]     ch_wdata [NUM_CH];
    logic [DATA_W-1:0]     ch_rdata [NUM_CH];
    logic                  started, paused, err_flag, no_data;

    // Gather per-channel inputs into indexed vectors (0 = left, 1 = right).
    always_comb begin
        ch_wr       = {wr_right, wr_left};
        ch_rd       = {pop_right, pop_left};
        ch_eot      = {eot_right, eot_left};
        ch_sreg     = {sreg_empty_right, sreg_empty_left};
        ch_wdata[0] = wr_data_left;
        ch_wdata[1] = wr_data_right;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        i2s_txst_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_wr[c]),
            .wr_data (ch_wdata[c]),
            .rd_en   (ch_rd[c]),
            .rd_data (ch_rdata[c]),
            .empty   (ch_empty[c]),
            .room    (ch_room[c]),
            .half    (ch_half[c])
        );
        // Completion per channel, by feed mode.
        always_comb begin
            if (dma_mode) ch_done[c] = started && ch_eot[c] && ch_sreg[c];
            else          ch_done[c] = started && !enable && ch_empty[c] && ch_sreg[c];
        end
    end

    assign rd_data_left  = ch_rdata[0];
    assign rd_data_right = ch_rdata[1];

    // Remember that the transmitter has been switched on since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      started <= 1'b0;
        else if (enable) started <= 1'b1;
    end

    // Acknowledge a pause only at a frame boundary with both shifters idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !pause_req)                           paused <= 1'b0;
        else if (frame_edge && ch_sreg[0] && ch_sreg[1])    paused <= 1'b1;
    end

    i2s_txst_err #(.CODE_W(CODE_W)) u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_pulse   (err_pulse),
        .err_code_in (err_code_in),
        .err_clr     (err_clr),
        .err_flag    (err_flag),
        .err_code    (err_code)
    );

    // Starvation in DMA feed: nothing ready but no end-of-transfer either.
    assign no_data = dma_mode && !sock_has_data && !ch_eot[0] && !ch_eot[1];

    // Assemble the status word.
    always_comb begin
        status             = '0;
        status[BIT_L_DONE] = ch_done[0];
        status[BIT_L_ROOM] = ch_room[0];
        status[BIT_L_HALF] = ch_half[0];
        status[BIT_R_DONE] = ch_done[1];
        status[BIT_R_ROOM] = ch_room[1];
        status[BIT_R_HALF] = ch_half[1];
        status[BIT_PAUSED] = paused;
        status[BIT_NODATA] = no_data;
        status[BIT_ERROR]  = err_flag;
    end

    assert_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_L_DONE] || status[BIT_R_DONE]) |-> started);
    assert_reg_done_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode && (status[BIT_L_DONE] || status[BIT_R_DONE])) |-> !enable);
    assert_pause_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(frame_edge && pause_req));
    assert_nodata_dma_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |-> !status[BIT_NODATA]);
endmodule

// File: tb/i2s_tx_status_tb_top.sv
// Bench: reference model of queues, start, pause and error state, driven
// by seeded random stimulus plus directed corner steps.
module i2s_tx_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_left = 0, wr_right = 0, pop_left = 0, pop_right = 0;
    logic [15:0] wr_data_left = 0, wr_data_right = 0;
    logic [15:0] rd_data_left, rd_data_right;
    logic        enable = 0, pause_req = 0, frame_edge = 0, dma_mode = 0;
    logic        eot_left = 0, eot_right = 0, sock_has_data = 0;
    logic        sreg_empty_left = 1, sreg_empty_right = 1;
    logic        err_pulse = 0, err_clr = 0;
    logic [3:0]  err_code_in = 0;
    logic [8:0]  status;
    logic [3:0]  err_code;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    // Reference model state
    logic [15:0] q_l[$], q_r[$];
    bit          m_started = 0, m_paused = 0, m_err = 0;
    logic [3:0]  m_code = 0;

    i2s_tx_status dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_left(wr_left), .wr_data_left(wr_data_left),
        .wr_right(wr_right), .wr_data_right(wr_data_right),
        .pop_left(pop_left), .pop_right(pop_right),
        .rd_data_left(rd_data_left), .rd_data_right(rd_data_right),
        .enable(enable), .pause_req(pause_req), .frame_edge(frame_edge),
        .dma_mode(dma_mode), .eot_left(eot_left), .eot_right(eot_right),
        .sock_has_data(sock_has_data),
        .sreg_empty_left(sreg_empty_left), .sreg_empty_right(sreg_empty_right),
        .err_pulse(err_pulse), .err_code_in(err_code_in), .err_clr(err_clr),
        .status(status), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_done(input bit eot, input bit se, input int occ);
        if (dma_mode) return m_started && eot && se;              // R6
        return m_started && !enable && occ == 0 && se;            // R5
    endfunction

    function automatic logic [8:0] exp_status();
        logic [8:0] s;
        s[0] = exp_done(eot_left, sreg_empty_left, q_l.size());
        s[1] = q_l.size() < DEPTH;
        s[2] = q_l.size() <= DEPTH/2;
        s[3] = exp_done(eot_right, sreg_empty_right, q_r.size());
        s[4] = q_r.size() < DEPTH;
        s[5] = q_r.size() <= DEPTH/2;
        s[6] = m_paused;
        s[7] = dma_mode && !sock_has_data && !eot_left && !eot_right;
        s[8] = m_err;
        return s;
    endfunction

    // Check at the falling edge, then advance the model at the rising edge.
    task automatic step();
        logic [8:0] e;
        @(negedge clk);
        e = exp_status();
        chk("R1 status word", 32'(status), 32'(e));
        chk(dma_mode ? "R6 left done" : "R5 left done", 32'(status[0]), 32'(e[0]));
        chk(dma_mode ? "R6 right done" : "R5 right done", 32'(status[3]), 32'(e[3]));
        chk("R3 space/half", 32'({status[5:4], status[2:1]}), 32'({e[5:4], e[2:1]}));
        chk("R8 paused", 32'(status[6]), 32'(e[6]));
        chk("R9 no-data", 32'(status[7]), 32'(e[7]));
        chk("R10 error", 32'(status[8]), 32'(e[8]));
        chk("R11 code", 32'(err_code), 32'(m_code));
        if (q_l.size() > 0) chk("R4 left head", 32'(rd_data_left), 32'(q_l[0]));
        if (q_r.size() > 0) chk("R4 right head", 32'(rd_data_right), 32'(q_r[0]));
        @(posedge clk);
        begin
            int ol = q_l.size();
            int orr = q_r.size();
            if (pop_left && ol > 0) void'(q_l.pop_front());
            if (wr_left && ol < DEPTH) q_l.push_back(wr_data_left);
            if (pop_right && orr > 0) void'(q_r.pop_front());
            if (wr_right && orr < DEPTH) q_r.push_back(wr_data_right);
        end
        if (enable) m_started = 1;
        if (!pause_req) m_paused = 0;
        else if (frame_edge && sreg_empty_left && sreg_empty_right) m_paused = 1;
        if (err_pulse && (!m_err || err_clr)) m_code = err_code_in;
        m_err = err_pulse || (m_err && !err_clr);
        #1;
    endtask

    task automatic idle();
        wr_left = 0; wr_right = 0; pop_left = 0; pop_right = 0;
        frame_edge = 0; err_pulse = 0; err_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R2: reset values
        @(negedge clk);
        chk("R2 reset status", 32'(status), 32'h036);
        chk("R2 reset code", 32'(err_code), 32'h0);
        @(posedge clk); #1;
        // R7: no done before any enable, in either mode
        step();
        dma_mode = 1; eot_left = 1; eot_right = 1; step();
        chk("R7 done before start", 32'({status[3], status[0]}), 32'h0);
        dma_mode = 0; eot_left = 0; eot_right = 0;
        // R3: fill left to full and beyond, also right
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr_left = 1; wr_data_left = 16'(16'h1000 + i);
            wr_right = (i % 2 == 0); wr_data_right = 16'(16'h2000 + i);
            step();
        end
        // R3: write and pop together on a full queue
        wr_left = 1; pop_left = 1; wr_data_left = 16'hBEEF; step();
        idle(); step();
        // R5: drain with enable high, then drop enable
        enable = 1;
        for (int i = 0; i < DEPTH + 2; i++) begin
            pop_left = 1; pop_right = 1; step();
        end
        idle(); step();
        enable = 0; step();
        chk("R5 done after drain", 32'({status[3], status[0]}), 32'h3);
        // R10/R11: error collisions
        err_pulse = 1; err_code_in = 4'h5; step();
        err_code_in = 4'hA; step();
        err_pulse = 0; step();
        chk("R11 first code kept", 32'(err_code), 32'h5);
        err_pulse = 1; err_clr = 1; err_code_in = 4'hC; step();
        err_pulse = 0; err_clr = 0; step();
        chk("R10 set wins over clear", 32'(status[8]), 32'h1);
        chk("R11 code at collision", 32'(err_code), 32'hC);
        err_clr = 1; step();
        err_clr = 0; step();
        chk("R10 cleared", 32'(status[8]), 32'h0);
        // R8: pause with busy shifter, then at an idle frame edge
        pause_req = 1; frame_edge = 1; sreg_empty_left = 0; step();
        sreg_empty_left = 1; step();
        frame_edge = 0; step();
        chk("R8 paused after idle edge", 32'(status[6]), 32'h1);
        pause_req = 0; step();
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            wr_left  = ($urandom % 3) == 0; wr_data_left  = 16'($urandom);
            wr_right = ($urandom % 3) == 0; wr_data_right = 16'($urandom);
            pop_left = ($urandom % 3) == 0; pop_right = ($urandom % 3) == 0;
            if ($urandom % 25 == 0) enable = ~enable;
            if ($urandom % 40 == 0) dma_mode = ~dma_mode;
            if ($urandom % 15 == 0) pause_req = ~pause_req;
            frame_edge = ($urandom % 4) == 0;
            eot_left = ($urandom % 4) == 0; eot_right = ($urandom % 4) == 0;
            sock_has_data = $urandom % 2;
            sreg_empty_left = $urandom % 2; sreg_empty_right = $urandom % 2;
            err_pulse = ($urandom % 20) == 0; err_code_in = 4'($urandom);
            err_clr = ($urandom % 8) == 0;
            step();
        end
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule